// File: doc/BRIEF.md
# Descriptor-Driven Configuration Item DMA Engine

This block moves bytes between system memory and a configuration item store without software touching the item data port one byte at a time. Software builds a 16-byte descriptor in memory, then writes the descriptor's address into a 64-bit doorbell register. The engine fetches the descriptor and, if asked, selects a new item. It then either copies item bytes out to memory, copies memory bytes into the item, or advances the item offset. At the end it writes a 32-bit status word over the first four bytes of the descriptor, so software can poll memory for the outcome.

The memory side is a byte-wide request/acknowledge master with an error flag. The item side drives a select strobe with a key and a per-byte step strobe, with optional write data. It reads back the current item's presence, write permission, length, offset and data byte. The item store itself is external to the block. A busy output stays high from the doorbell until the status word has been written.

Top module: `cfgdma_engine`

## Requirements
- R1: After synchronous reset, busy, mem_req, sel_stb, step_stb and reg_ack are all low.
- R2: A 4-byte register write at offset 0 loads doorbell address bits 63:32. A 4-byte write at offset 4 loads bits 31:0 and starts a run. An 8-byte write at offset 0 loads all 64 bits and starts a run. A run first reads 16 descriptor bytes at ascending addresses from the doorbell address.
- R3: Any other register write shape returns reg_err=1 together with reg_ack, and it neither changes the doorbell address nor starts a run.
- R4: A register read of reg_size bytes at reg_addr returns signature bytes reg_addr through reg_addr+reg_size-1, where byte 0 is the most significant, right-aligned in reg_rdata. A read that runs past byte 7 returns reg_err=1 and reg_rdata=0.
- R5: The descriptor is big-endian. Bytes 0-3 hold the control word, bytes 4-7 hold the length and bytes 8-15 hold the target memory address.
- R6: When control bit 3 (value 0x08) is set, exactly one sel_stb pulse carries control bits 31:16 as the key, and it comes before any data movement. The item offset restarts at 0 in the store.
- R7: The operation is chosen as read (0x02), then write (0x10), then skip (0x04). A control word with none of these bits moves no data and completes cleanly.
- R8: A read copies item bytes from the current offset to ascending target addresses. Once the item is absent or exhausted, it writes zero bytes for the rest of the length and still completes cleanly.
- R9: A write copies memory bytes into the item at ascending offsets. An absent, exhausted or write-protected item sets the error and stops the transfer, leaving later bytes untouched.
- R10: A skip advances the item offset by the length without any memory access. If the item is exhausted before the length is used up, it sets the error.
- R11: A memory access that returns mem_err sets the error and stops the transfer. The failing byte does not advance the item offset.
- R12: If a descriptor byte fetch fails, no item operation happens, and 0x00000001 is written to descriptor bytes 0-3.
- R13: Completion writes the status big-endian to descriptor bytes 0-3. The status is 0x00000000 for a clean run and 0x00000001 for an error.
- R14: Doorbell writes while busy is high are acknowledged without error but dropped, with no effect on the running or any later transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register byte offset |
| reg_size | input | 4 | Access size in bytes |
| reg_wdata | input | 64 | Write data, right-aligned |
| reg_ack | output | 1 | Access completed (one cycle after strobe) |
| reg_err | output | 1 | Access rejected |
| reg_rdata | output | 64 | Read data, right-aligned |
| busy | output | 1 | Transfer in progress |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_ack | input | 1 | Memory response |
| mem_rdata | input | 8 | Memory read byte, valid with mem_ack |
| mem_err | input | 1 | Memory access failed, valid with mem_ack |
| sel_stb | output | 1 | Select a new item |
| sel_key | output | 16 | Key of the item to select |
| item_present | input | 1 | Selected item exists |
| item_wr_ok | input | 1 | Selected item accepts writes |
| item_len | input | 32 | Selected item length in bytes |
| item_off | input | 32 | Current item byte offset |
| item_rdata | input | 8 | Item byte at the current offset |
| step_stb | output | 1 | Advance item offset by one |
| step_we | output | 1 | Store step_wdata at the current offset before advancing |
| step_wdata | output | 8 | Byte written into the item |

## Verification
Register results (reg_ack, reg_err, reg_rdata) are due one clock after the strobe is sampled, so the bench drives at a falling edge and reads them at the next falling edge. A doorbell raises busy two clocks later: one clock for the start pulse and one for the controller to leave idle. The bench waits two falling edges before it polls busy. Memory and item effects are only checked once busy has dropped, because the last status byte is written before busy clears. Tests that rely on a dropped doorbell confirm busy is already high before the extra write is issued.

// File: rtl/cfgdma_pkg.sv
package cfgdma_pkg;
  // control word bit positions (software-visible encoding)
  localparam int CTL_ERR  = 0;
  localparam int CTL_RD   = 1;
  localparam int CTL_SKIP = 2;
  localparam int CTL_SEL  = 3;
  localparam int CTL_WR   = 4;

  localparam int DESC_BYTES = 16;
  localparam int STAT_BYTES = 4;
  localparam int KEY_W      = 16;
  localparam int XLEN_W     = 32;
  localparam int MADDR_W    = 64;

  typedef enum logic [1:0] {OP_NONE, OP_READ, OP_WRITE, OP_SKIP} op_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FETCH, ST_DECODE, ST_SEL, ST_XFER,
    ST_MEMW, ST_STEP, ST_WB, ST_DONE
  } st_e;
endpackage

// File: rtl/cfgdma_regs.sv
module cfgdma_regs #(
  parameter logic [63:0] SIGNATURE = 64'h5A3C_C3A5_0F1E_2D4B
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [3:0]  reg_size,
  input  logic [63:0] reg_wdata,
  input  logic        busy,
  output logic        reg_ack,
  output logic        reg_err,
  output logic [63:0] reg_rdata,
  output logic        go,
  output logic [63:0] go_addr
);
  logic       shape_ok;
  logic [4:0] rd_end;
  logic       rd_ok;
  logic [4:0] rd_gap;
  logic [63:0] rd_mask;
  logic [63:0] rd_val;

  always_comb begin
    shape_ok = ((reg_size == 4'd4) && ((reg_addr == 3'd0) || (reg_addr == 3'd4))) ||
               ((reg_size == 4'd8) && (reg_addr == 3'd0));
    rd_end   = {2'b00, reg_addr} + {1'b0, reg_size};
    rd_ok    = (reg_size != 4'd0) && (rd_end <= 5'd8);
    rd_gap   = 5'd8 - rd_end;
    rd_mask  = (reg_size == 4'd8) ? {64{1'b1}} : ~({64{1'b1}} << {reg_size, 3'b000});
    rd_val   = (SIGNATURE >> {rd_gap, 3'b000}) & rd_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_ack   <= 1'b0;
      reg_err   <= 1'b0;
      reg_rdata <= '0;
      go        <= 1'b0;
      go_addr   <= '0;
    end else begin
      reg_ack <= reg_wr | reg_rd;
      reg_err <= 1'b0;
      go      <= 1'b0;
      if (reg_wr) begin
        if (!shape_ok) begin
          reg_err <= 1'b1;
        end else if (!busy) begin
          if (reg_size == 4'd8) begin
            go_addr <= reg_wdata;
            go      <= 1'b1;
          end else if (reg_addr == 3'd0) begin
            go_addr[63:32] <= reg_wdata[31:0];
          end else begin
            go_addr[31:0] <= reg_wdata[31:0];
            go            <= 1'b1;
          end
        end
      end else if (reg_rd) begin
        if (rd_ok) begin
          reg_rdata <= rd_val;
        end else begin
          reg_rdata <= '0;
          reg_err   <= 1'b1;
        end
      end
    end
  end

  AST_ERR_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
    reg_err |-> reg_ack); // R3
  AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    go |-> !busy); // R14
  AST_GO_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    go |-> $past(reg_wr)); // R2
endmodule

// File: rtl/cfgdma_ctrl.sv
module cfgdma_ctrl
  import cfgdma_pkg::*;
#(
  parameter int ITEM_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                go,
  input  logic [MADDR_W-1:0]  go_addr,
  output logic                busy,
  output logic                mem_req,
  output logic                mem_we,
  output logic [MADDR_W-1:0]  mem_addr,
  output logic [7:0]          mem_wdata,
  input  logic                mem_ack,
  input  logic [7:0]          mem_rdata,
  input  logic                mem_err,
  output logic                sel_stb,
  output logic [KEY_W-1:0]    sel_key,
  input  logic                item_present,
  input  logic                item_wr_ok,
  input  logic [ITEM_W-1:0]   item_len,
  input  logic [ITEM_W-1:0]   item_off,
  input  logic [7:0]          item_rdata,
  output logic                step_stb,
  output logic                step_we,
  output logic [7:0]          step_wdata
);
  localparam int DIDX_W = $clog2(DESC_BYTES);
  localparam int SIDX_W = $clog2(STAT_BYTES);
  localparam int DBITS  = DESC_BYTES * 8;

  st_e                 state_q;
  op_e                 op_q;
  logic [MADDR_W-1:0]  base_q;
  logic [MADDR_W-1:0]  taddr_q;
  logic [XLEN_W-1:0]   left_q;
  logic [DBITS-1:0]    desc_q;
  logic [DIDX_W-1:0]   fidx_q;
  logic [SIDX_W-1:0]   widx_q;
  logic                err_q;
  logic                hold_exh_q;

  logic                exhausted;
  logic [31:0]         ctl_w;
  op_e                 op_pick;
  logic [7:0]          wb_byte;

  always_comb begin
    exhausted = !item_present || (item_off >= item_len);
    ctl_w     = desc_q[DBITS-1 -: 32];
    if (ctl_w[CTL_RD])        op_pick = OP_READ;
    else if (ctl_w[CTL_WR])   op_pick = OP_WRITE;
    else if (ctl_w[CTL_SKIP]) op_pick = OP_SKIP;
    else                      op_pick = OP_NONE;
    wb_byte = (widx_q == SIDX_W'(STAT_BYTES - 1)) ? {7'd0, err_q} : 8'd0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      op_q       <= OP_NONE;
      base_q     <= '0;
      taddr_q    <= '0;
      left_q     <= '0;
      desc_q     <= '0;
      fidx_q     <= '0;
      widx_q     <= '0;
      err_q      <= 1'b0;
      hold_exh_q <= 1'b0;
      busy       <= 1'b0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      sel_stb    <= 1'b0;
      sel_key    <= '0;
      step_stb   <= 1'b0;
      step_we    <= 1'b0;
      step_wdata <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (go) begin
            base_q  <= go_addr;
            fidx_q  <= '0;
            widx_q  <= '0;
            err_q   <= 1'b0;
            busy    <= 1'b1;
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (!mem_req) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= base_q + MADDR_W'(fidx_q);
          end else if (mem_ack) begin
            mem_req <= 1'b0;
            if (mem_err) begin
              err_q   <= 1'b1;
              state_q <= ST_WB;
            end else begin
              desc_q <= {desc_q[DBITS-9:0], mem_rdata};
              if (fidx_q == DIDX_W'(DESC_BYTES - 1)) state_q <= ST_DECODE;
              else fidx_q <= fidx_q + 1'b1;
            end
          end
        end
        ST_DECODE: begin
          op_q    <= op_pick;
          left_q  <= desc_q[DBITS-33 -: XLEN_W];
          taddr_q <= desc_q[MADDR_W-1:0];
          if (ctl_w[CTL_SEL]) begin
            sel_stb <= 1'b1;
            sel_key <= ctl_w[31 -: KEY_W];
            state_q <= ST_SEL;
          end else begin
            state_q <= ST_XFER;
          end
        end
        ST_SEL: begin
          sel_stb <= 1'b0;
          state_q <= ST_XFER;
        end
        ST_XFER: begin
          if ((left_q == '0) || err_q || (op_q == OP_NONE)) begin
            state_q <= ST_WB;
          end else begin
            case (op_q)
              OP_READ: begin
                mem_req    <= 1'b1;
                mem_we     <= 1'b1;
                mem_addr   <= taddr_q;
                mem_wdata  <= exhausted ? 8'd0 : item_rdata;
                hold_exh_q <= exhausted;
                state_q    <= ST_MEMW;
              end
              OP_WRITE: begin
                if (exhausted || !item_wr_ok) begin
                  err_q <= 1'b1;
                end else begin
                  mem_req  <= 1'b1;
                  mem_we   <= 1'b0;
                  mem_addr <= taddr_q;
                  state_q  <= ST_MEMW;
                end
              end
              OP_SKIP: begin
                if (exhausted) begin
                  err_q <= 1'b1;
                end else begin
                  step_stb <= 1'b1;
                  step_we  <= 1'b0;
                  taddr_q  <= taddr_q + 1'b1;
                  left_q   <= left_q - 1'b1;
                  state_q  <= ST_STEP;
                end
              end
              default: state_q <= ST_WB;
            endcase
          end
        end
        ST_MEMW: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            if (mem_err) begin
              err_q   <= 1'b1;
              state_q <= ST_XFER;
            end else begin
              taddr_q <= taddr_q + 1'b1;
              left_q  <= left_q - 1'b1;
              if (op_q == OP_WRITE) begin
                step_stb   <= 1'b1;
                step_we    <= 1'b1;
                step_wdata <= mem_rdata;
                state_q    <= ST_STEP;
              end else if (!hold_exh_q) begin
                step_stb <= 1'b1;
                step_we  <= 1'b0;
                state_q  <= ST_STEP;
              end else begin
                state_q <= ST_XFER;
              end
            end
          end
        end
        ST_STEP: begin
          step_stb <= 1'b0;
          step_we  <= 1'b0;
          state_q  <= ST_XFER;
        end
        ST_WB: begin
          if (!mem_req) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= base_q + MADDR_W'(widx_q);
            mem_wdata <= wb_byte;
          end else if (mem_ack) begin
            mem_req <= 1'b0;
            if (widx_q == SIDX_W'(STAT_BYTES - 1)) state_q <= ST_DONE;
            else widx_q <= widx_q + 1'b1;
          end
        end
        ST_DONE: begin
          busy    <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R2
  AST_WB_WRITES_ONLY: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WB && mem_req) |-> mem_we); // R13
  AST_SEL_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sel_stb |=> !sel_stb); // R6
  AST_STEP_MEM_IDLE: assert property (@(posedge clk) disable iff (rst)
    step_stb |-> !mem_req); // R10
  AST_STEP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    step_stb |=> !step_stb); // R8
endmodule

// File: rtl/cfgdma_engine.sv
module cfgdma_engine
  import cfgdma_pkg::*;
#(
  parameter logic [63:0] SIGNATURE = 64'h5A3C_C3A5_0F1E_2D4B,
  parameter int          ITEM_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [3:0]        reg_size,
  input  logic [63:0]       reg_wdata,
  output logic              reg_ack,
  output logic              reg_err,
  output logic [63:0]       reg_rdata,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [63:0]       mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_ack,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_err,
  output logic              sel_stb,
  output logic [15:0]       sel_key,
  input  logic              item_present,
  input  logic              item_wr_ok,
  input  logic [ITEM_W-1:0] item_len,
  input  logic [ITEM_W-1:0] item_off,
  input  logic [7:0]        item_rdata,
  output logic              step_stb,
  output logic              step_we,
  output logic [7:0]        step_wdata
);
  logic        go;
  logic [63:0] go_addr;

  cfgdma_regs #(.SIGNATURE(SIGNATURE)) regs_i (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_size(reg_size), .reg_wdata(reg_wdata), .busy(busy),
    .reg_ack(reg_ack), .reg_err(reg_err), .reg_rdata(reg_rdata),
    .go(go), .go_addr(go_addr)
  );

  cfgdma_ctrl #(.ITEM_W(ITEM_W)) ctrl_i (
    .clk(clk), .rst(rst), .go(go), .go_addr(go_addr), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .mem_err(mem_err), .sel_stb(sel_stb), .sel_key(sel_key),
    .item_present(item_present), .item_wr_ok(item_wr_ok),
    .item_len(item_len), .item_off(item_off), .item_rdata(item_rdata),
    .step_stb(step_stb), .step_we(step_we), .step_wdata(step_wdata)
  );
endmodule

// File: tb/cfgdma_engine_tb_top.sv
module cfgdma_engine_tb_top;
  localparam logic [63:0] SIG = 64'h5A3C_C3A5_0F1E_2D4B;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        reg_wr = 0, reg_rd = 0;
  logic [2:0]  reg_addr = 0;
  logic [3:0]  reg_size = 0;
  logic [63:0] reg_wdata = 0;
  logic        reg_ack, reg_err, busy;
  logic [63:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [63:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_ack = 0, mem_err = 0;
  logic [7:0]  mem_rdata = 0;
  logic        sel_stb, step_stb, step_we;
  logic [15:0] sel_key;
  logic [7:0]  step_wdata, item_rdata;
  logic        item_present, item_wr_ok;
  logic [31:0] item_len, item_off;

  cfgdma_engine dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_size(reg_size), .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_err(reg_err),
    .reg_rdata(reg_rdata), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .mem_err(mem_err), .sel_stb(sel_stb), .sel_key(sel_key),
    .item_present(item_present), .item_wr_ok(item_wr_ok), .item_len(item_len),
    .item_off(item_off), .item_rdata(item_rdata), .step_stb(step_stb),
    .step_we(step_we), .step_wdata(step_wdata)
  );

  // memory model: reads fail at 0xF0 and above, writes at 0xF8 and above
  logic [7:0] mem [0:255];
  logic       poke_en = 0;
  logic [7:0] poke_a = 0, poke_d = 0;
  int         acc_cnt = 0;
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (poke_en) mem[poke_a] <= poke_d;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      acc_cnt <= acc_cnt + 1;
      if (mem_we) begin
        mem_err <= (mem_addr[7:0] >= 8'hF8);
        if (mem_addr[7:0] < 8'hF8) mem[mem_addr[7:0]] <= mem_wdata;
      end else begin
        mem_err   <= (mem_addr[7:0] >= 8'hF0);
        mem_rdata <= mem[mem_addr[7:0]];
      end
    end
  end

  // item store model: keys 0..2 exist, key 2 writable
  logic [7:0]  items [0:63];
  logic [15:0] cur_key;
  logic [31:0] cur_off;
  int          sel_cnt = 0;
  logic [15:0] last_key = 0;
  assign item_present = (cur_key < 16'd3);
  assign item_wr_ok   = (cur_key == 16'd2);
  assign item_len     = (cur_key == 16'd0) ? 32'd6 : 32'd4;
  assign item_off     = cur_off;
  assign item_rdata   = items[{cur_key[1:0], cur_off[3:0]}];
  always @(posedge clk) begin
    if (rst) begin
      cur_key <= 0;
      cur_off <= 0;
      for (int i = 0; i < 64; i++) items[i] <= 8'(((i / 16) + 1) * 16 + (i % 16));
    end else if (sel_stb) begin
      cur_key  <= sel_key;
      cur_off  <= 0;
      sel_cnt  <= sel_cnt + 1;
      last_key <= sel_key;
    end else if (step_stb) begin
      if (step_we) items[{cur_key[1:0], cur_off[3:0]}] <= step_wdata;
      cur_off <= cur_off + 1;
    end
  end

  function automatic logic [7:0] init_b(input int k, input int o);
    return 8'((k + 1) * 16 + o);
  endfunction

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic reg_acc(input bit wr, input logic [2:0] a, input logic [3:0] sz,
                         input logic [63:0] d, output logic ack, output logic err,
                         output logic [63:0] rd);
    @(negedge clk);
    reg_wr = wr; reg_rd = !wr; reg_addr = a; reg_size = sz; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_rd = 0;
    ack = reg_ack; err = reg_err; rd = reg_rdata;
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    poke_en = 1; poke_a = a; poke_d = d;
    @(negedge clk);
    poke_en = 0;
  endtask

  task automatic put_desc(input logic [7:0] b, input logic [31:0] ctl,
                          input logic [31:0] len, input logic [7:0] ta);
    for (int i = 0; i < 4; i++) poke(b + 8'(i), ctl[31 - 8*i -: 8]);
    for (int i = 0; i < 4; i++) poke(b + 8'(4 + i), len[31 - 8*i -: 8]);
    for (int i = 0; i < 7; i++) poke(b + 8'(8 + i), 8'h00);
    poke(b + 8'd15, ta);
  endtask

  task automatic wait_idle();
    int g = 0;
    repeat (2) @(negedge clk);
    while (busy && g < 5000) begin
      @(negedge clk);
      g++;
    end
  endtask

  task automatic ring(input logic [7:0] b, input bit wide);
    logic a, e;
    logic [63:0] r;
    if (wide) reg_acc(1, 3'd0, 4'd8, {56'd0, b}, a, e, r);
    else begin
      reg_acc(1, 3'd0, 4'd4, 64'd0, a, e, r);
      reg_acc(1, 3'd4, 4'd4, {56'd0, b}, a, e, r);
    end
    wait_idle();
  endtask

  function automatic logic [31:0] stat(input logic [7:0] b);
    return {mem[b], mem[b + 8'd1], mem[b + 8'd2], mem[b + 8'd3]};
  endfunction

  task automatic t_reset();
    chk("R1", "busy", busy, 0);
    chk("R1", "mem_req", mem_req, 0);
    chk("R1", "sel_stb", sel_stb, 0);
    chk("R1", "step_stb", step_stb, 0);
    chk("R1", "reg_ack", reg_ack, 0);
  endtask

  task automatic t_sig();
    logic a, e;
    logic [63:0] r;
    reg_acc(0, 3'd0, 4'd8, 0, a, e, r);
    chk("R4", "read8 data", r, SIG);
    chk("R4", "read8 ack/err", {a, e}, 2'b10);
    reg_acc(0, 3'd3, 4'd2, 0, a, e, r);
    chk("R4", "read2@3", r, {48'd0, SIG[39:24]});
    reg_acc(0, 3'd7, 4'd1, 0, a, e, r);
    chk("R4", "read1@7", r, {56'd0, SIG[7:0]});
    reg_acc(0, 3'd6, 4'd4, 0, a, e, r);
    chk("R4", "overrun read", {a, e, r}, {2'b11, 64'd0});
  endtask

  task automatic t_badwr();
    logic a, e;
    logic [63:0] r;
    reg_acc(1, 3'd0, 4'd2, 64'h40, a, e, r);
    chk("R3", "2-byte write rejected", {a, e}, 2'b11);
    reg_acc(1, 3'd2, 4'd4, 64'h40, a, e, r);
    chk("R3", "4-byte write @2 rejected", {a, e}, 2'b11);
    repeat (4) @(negedge clk);
    chk("R3", "no run started", busy, 0);
  endtask

  task automatic t_read_fill();
    int s0 = sel_cnt;
    for (int i = 0; i < 11; i++) poke(8'h40 + 8'(i), 8'hEE);
    put_desc(8'h00, 32'h0000_000A, 32'd10, 8'h40);
    ring(8'h00, 0);
    for (int i = 0; i < 6; i++) chk("R8", "read byte", mem[8'h40 + 8'(i)], init_b(0, i));
    for (int i = 6; i < 10; i++) chk("R8", "zero fill", mem[8'h40 + 8'(i)], 0);
    chk("R5", "untouched past length", mem[8'h4A], 8'hEE);
    chk("R6", "one select", sel_cnt - s0, 1);
    chk("R6", "select key", last_key, 0);
    chk("R13", "clean status", stat(8'h00), 0);
  endtask

  task automatic t_priority();
    for (int i = 0; i < 4; i++) poke(8'h50 + 8'(i), 8'hEE);
    put_desc(8'h10, 32'h0001_001E, 32'd4, 8'h50);
    ring(8'h10, 1);
    for (int i = 0; i < 4; i++) chk("R7", "read wins", mem[8'h50 + 8'(i)], init_b(1, i));
    chk("R7", "item1 untouched", items[16], init_b(1, 0));
    chk("R7", "status", stat(8'h10), 0);
    poke(8'h60, 8'hA1); poke(8'h61, 8'hA2);
    put_desc(8'h10, 32'h0002_001C, 32'd2, 8'h60);
    ring(8'h10, 1);
    chk("R9", "write over skip b0", items[32], 8'hA1);
    chk("R9", "write over skip b1", items[33], 8'hA2);
    chk("R7", "write status", stat(8'h10), 0);
  endtask

  task automatic t_write_err();
    for (int i = 0; i < 4; i++) poke(8'h62 + 8'(i), 8'hB1 + 8'(i));
    put_desc(8'h10, 32'h0000_0010, 32'd4, 8'h62);
    ring(8'h10, 1);
    chk("R9", "item2 b2", items[34], 8'hB1);
    chk("R9", "item2 b3", items[35], 8'hB2);
    chk("R9", "overflow error", stat(8'h10), 1);
    put_desc(8'h10, 32'h0001_0018, 32'd2, 8'h60);
    ring(8'h10, 1);
    chk("R9", "read-only untouched", items[16], init_b(1, 0));
    chk("R9", "read-only error", stat(8'h10), 1);
  endtask

  task automatic t_skip();
    int c0;
    put_desc(8'h10, 32'h0000_000C, 32'd3, 8'h00);
    c0 = acc_cnt;
    ring(8'h10, 1);
    chk("R10", "no memory access", acc_cnt - c0, 20);
    chk("R10", "skip status", stat(8'h10), 0);
    put_desc(8'h10, 32'h0000_0002, 32'd2, 8'h70);
    ring(8'h10, 1);
    chk("R10", "after skip b0", mem[8'h70], init_b(0, 3));
    chk("R10", "after skip b1", mem[8'h71], init_b(0, 4));
    put_desc(8'h10, 32'h0000_0004, 32'd2, 8'h00);
    ring(8'h10, 1);
    chk("R10", "skip past end error", stat(8'h10), 1);
    poke(8'h72, 8'hEE);
    put_desc(8'h10, 32'h0000_0002, 32'd1, 8'h72);
    ring(8'h10, 1);
    chk("R10", "offset at end", mem[8'h72], 0);
  endtask

  task automatic t_absent();
    for (int i = 0; i < 4; i++) poke(8'h74 + 8'(i), 8'hEE);
    put_desc(8'h10, 32'h0003_000A, 32'd3, 8'h74);
    ring(8'h10, 1);
    for (int i = 0; i < 3; i++) chk("R8", "absent zeros", mem[8'h74 + 8'(i)], 0);
    chk("R8", "absent length bound", mem[8'h77], 8'hEE);
    chk("R8", "absent read clean", stat(8'h10), 0);
    put_desc(8'h10, 32'h0003_0018, 32'd1, 8'h60);
    ring(8'h10, 1);
    chk("R9", "absent write error", stat(8'h10), 1);
  endtask

  task automatic t_none();
    int c0;
    for (int i = 0; i < 5; i++) poke(8'h78 + 8'(i), 8'hEE);
    put_desc(8'h10, 32'h0000_0000, 32'd5, 8'h78);
    c0 = acc_cnt;
    ring(8'h10, 1);
    chk("R7", "no-op accesses", acc_cnt - c0, 20);
    chk("R7", "no-op target", mem[8'h78], 8'hEE);
    chk("R7", "no-op status", stat(8'h10), 0);
  endtask

  task automatic t_memerr();
    put_desc(8'h10, 32'h0000_000A, 32'd4, 8'hF6);
    ring(8'h10, 1);
    chk("R11", "byte before fault", mem[8'hF6], init_b(0, 0));
    chk("R11", "byte before fault 2", mem[8'hF7], init_b(0, 1));
    chk("R11", "memory error status", stat(8'h10), 1);
    poke(8'h7C, 8'hEE);
    put_desc(8'h10, 32'h0000_0002, 32'd1, 8'h7C);
    ring(8'h10, 1);
    chk("R11", "offset not advanced", mem[8'h7C], init_b(0, 2));
  endtask

  task automatic t_fetcherr();
    int c0;
    for (int i = 0; i < 4; i++) poke(8'hF0 + 8'(i), 8'hCC);
    c0 = acc_cnt;
    ring(8'hF0, 1);
    chk("R12", "fetch error status", stat(8'hF0), 1);
    chk("R12", "fetch stops early", acc_cnt - c0, 5);
  endtask

  task automatic t_busy();
    logic a, e;
    logic [63:0] r;
    for (int i = 0; i < 4; i++) poke(8'h30 + 8'(i), 8'hCC);
    poke(8'h90, 8'hEE);
    put_desc(8'h20, 32'h0000_000A, 32'd12, 8'h80);
    put_desc(8'h30, 32'h0000_0002, 32'd1, 8'h90);
    for (int i = 0; i < 4; i++) poke(8'h30 + 8'(i), 8'hCC);
    reg_acc(1, 3'd0, 4'd8, 64'h20, a, e, r);
    @(negedge clk);
    chk("R14", "busy before drop", busy, 1);
    reg_acc(1, 3'd0, 4'd8, 64'h30, a, e, r);
    chk("R14", "drop acked no error", {a, e}, 2'b10);
    reg_acc(1, 3'd4, 4'd4, 64'h30, a, e, r);
    wait_idle();
    repeat (6) @(negedge clk);
    chk("R14", "no second run", busy, 0);
    chk("R14", "second desc untouched", stat(8'h30), 32'hCCCC_CCCC);
    chk("R14", "second target untouched", mem[8'h90], 8'hEE);
    chk("R14", "first run status", stat(8'h20), 0);
    chk("R2", "first run data", mem[8'h80], init_b(0, 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_sig();
    t_badwr();
    t_read_fill();
    t_priority();
    t_write_err();
    t_skip();
    t_absent();
    t_none();
    t_memerr();
    t_fetcherr();
    t_busy();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule